// File: doc/BRIEF.md
# Stallable Processing Pipeline with Watermark Backpressure

The block runs input samples through a fixed-length chain of register stages. Each stage applies a small data transform, and the results land in an output FIFO that a downstream consumer drains through a read port. A valid bit travels with every word, so empty slots in the input stream move down the chain as bubbles and never become FIFO entries. The stages have no clock enable and are never held. Once a sample is accepted, it always arrives at the FIFO a fixed number of cycles later.

Flow control works through the source handshake only. When the FIFO occupancy reaches a threshold set by a parameter, the block drops its ready output and takes no new samples. The threshold is chosen so that every word already in the chain still fits in the FIFO. Elaboration rejects any setting where the threshold plus the stage count exceeds the FIFO depth. The space left above the threshold also keeps the reader supplied while the chain refills, because after ready returns it takes a full pipeline latency before new data reaches the FIFO.

Top module: `stall_pipe`

## Requirements
- R1: While rst_ni is low: in_ready_o=0, count_o=0, empty_o=1 and full_o=0. in_ready_o stays 0 until the first rising clock edge after reset is released.
- R2: A sample is accepted at a rising edge when in_valid_i=1 and in_ready_o=1. It is written into the FIFO exactly STAGES rising edges later, so count_o goes up by one after that edge.
- R3: Stage k, for k = 0 to STAGES-1 in order from the input, replaces its word x with (x rotated left by one bit) XOR k, where k is zero-extended to DATA_W bits.
- R4: A cycle with no accepted sample creates no FIFO entry. Accepted samples leave the FIFO in the order they were accepted.
- R5: After reset, in_ready_o is 1 when count_o < THRESH and 0 when count_o >= THRESH.
- R6: The FIFO never sees a write while it is full, and wr_drop_o never goes high. When the source keeps in_valid_i high and nothing is read, every accepted sample still lands in the FIFO.
- R7: rd_data_o always shows the oldest entry. rd_en_i=1 while empty_o=0 removes that entry at the next edge, and count_o goes down by one unless a write lands at the same edge.
- R8: rd_en_i=1 while empty_o=1 has no effect on count_o or the contents. rd_drop_o is 1 for exactly the cycle that follows that edge.
- R9: full_o=1 exactly when count_o=FIFO_DEPTH, and empty_o=1 exactly when count_o=0. With no reads and a steady input, the occupancy settles at THRESH+STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | DATA_W | Input sample |
| in_ready_o | output | 1 | Block accepts a sample at this edge |
| rd_en_i | input | 1 | Pop the FIFO head |
| rd_data_o | output | DATA_W | FIFO head word |
| full_o | output | 1 | FIFO holds FIFO_DEPTH words |
| empty_o | output | 1 | FIFO holds no word |
| count_o | output | $clog2(FIFO_DEPTH+1) | FIFO occupancy |
| wr_drop_o | output | 1 | A write hit a full FIFO at the previous edge |
| rd_drop_o | output | 1 | A read hit an empty FIFO at the previous edge |

## Verification
A sample accepted at edge k changes count_o after edge k+STAGES. The bench therefore drives inputs on falling edges and confirms that count_o is unchanged on the falling edge after edge k+STAGES-1 and has gone up by one on the next falling edge. in_ready_o, rd_data_o, full_o and empty_o are registered state, or logic fed only from registered state. They are sampled on the falling edge that follows each rising edge and compared with the occupancy at that moment. rd_drop_o is due one edge after the ignored read and is checked on that falling edge and on the one after it. Expected words come from a queue of accepted samples, each passed through the stage-by-stage transform, and are compared in pop order.

// File: rtl/stall_pipe_pkg.sv
package stall_pipe_pkg;
  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // In-flight words must always fit above the watermark.
  function automatic bit headroom_ok(input int unsigned thresh, input int unsigned stages,
                                     input int unsigned depth);
    return (thresh + stages) <= depth;
  endfunction
endpackage

// File: rtl/pipe_stage.sv
module pipe_stage #(
  parameter int unsigned W   = 30,
  parameter int unsigned IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  localparam logic [W-1:0] KEY = W'(IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dat_o <= {dat_i[W-2:0], dat_i[W-1]} ^ KEY;
    end
  end
endmodule

// File: rtl/pipe_chain.sv
module pipe_chain #(
  parameter int unsigned W      = 30,
  parameter int unsigned STAGES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [W-1:0]      dat_i,
  output logic              vld_o,
  output logic [W-1:0]      dat_o,
  output logic [STAGES-1:0] vld_vec_o
);
  logic [STAGES:0] vld;
  logic [W-1:0]    dat [STAGES+1];

  assign vld[0] = vld_i;
  assign dat[0] = dat_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    pipe_stage #(.W(W), .IDX(g)) u_stg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld[g]),
      .dat_i (dat[g]),
      .vld_o (vld[g+1]),
      .dat_o (dat[g+1])
    );
  end

  assign vld_o     = vld[STAGES];
  assign dat_o     = dat[STAGES];
  assign vld_vec_o = vld[STAGES:1];
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int unsigned W  = 30,
  parameter int unsigned D  = 128,
  localparam int unsigned PW = (D > 1) ? $clog2(D) : 1,
  localparam int unsigned CW = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdat_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdat_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o,
  output logic          wr_drop_o,
  output logic          rd_drop_o
);
  localparam logic [PW-1:0] LAST = PW'(D - 1);

  logic [W-1:0]  mem [D];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign full_o  = (cnt == CW'(D));
  assign empty_o = (cnt == '0);
  assign wr_ok   = wr_i & ~full_o;
  assign rd_ok   = rd_i & ~empty_o;
  assign rdat_o  = mem[rptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wptr] <= wdat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      wr_drop_o <= 1'b0;
      rd_drop_o <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      wr_drop_o <= wr_i & full_o;
      rd_drop_o <= rd_i & empty_o;
    end
  end
endmodule

// File: rtl/stall_pipe.sv
module stall_pipe #(
  parameter int unsigned DATA_W     = 30,
  parameter int unsigned STAGES     = 50,
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned THRESH     = 70,
  localparam int unsigned CW = stall_pipe_pkg::cnt_bits(FIFO_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o,
  output logic              wr_drop_o,
  output logic              rd_drop_o
);
  if (!stall_pipe_pkg::headroom_ok(THRESH, STAGES, FIFO_DEPTH)) begin : g_bad_cfg
    $error("THRESH + STAGES exceeds FIFO_DEPTH");
  end

  logic              run_q;
  logic              accept;
  logic              fifo_wr;
  logic [DATA_W-1:0] fifo_wdat;
  logic [STAGES-1:0] pipe_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign in_ready_o = run_q & (count_o < CW'(THRESH));
  assign accept     = in_valid_i & in_ready_o;

  pipe_chain #(.W(DATA_W), .STAGES(STAGES)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (accept),
    .dat_i    (in_data_i),
    .vld_o    (fifo_wr),
    .dat_o    (fifo_wdat),
    .vld_vec_o(pipe_vld)
  );

  sync_fifo #(.W(DATA_W), .D(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (fifo_wr),
    .wdat_i   (fifo_wdat),
    .rd_i     (rd_en_i),
    .rdat_o   (rd_data_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .count_o  (count_o),
    .wr_drop_o(wr_drop_o),
    .rd_drop_o(rd_drop_o)
  );
endmodule

// File: rtl/stall_pipe_chk.sv
module stall_pipe_chk #(
  parameter int unsigned STAGES     = 50,
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned THRESH     = 70,
  parameter int unsigned CW         = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              rd_en_i,
  input logic              full_o,
  input logic              empty_o,
  input logic [CW-1:0]     count_o,
  input logic              wr_drop_o,
  input logic              rd_drop_o,
  input logic              fifo_wr,
  input logic [STAGES-1:0] pipe_vld
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!in_ready_o && empty_o && count_o == '0);
  end

  assert_accept_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> pipe_vld[0]);

  assert_idle_bubble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !pipe_vld[0]);

  if (STAGES > 1) begin : g_shift
    assert_valid_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> pipe_vld[STAGES-1:1] == $past(pipe_vld[STAGES-2:0]));
  end

  assert_ready_watermark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o >= CW'(THRESH)) |-> !in_ready_o);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr |-> !full_o);

  assert_no_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_drop_o);

  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o && !fifo_wr) |=> (rd_drop_o && $stable(count_o)));

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(FIFO_DEPTH));
endmodule

bind stall_pipe stall_pipe_chk #(
  .STAGES(STAGES), .FIFO_DEPTH(FIFO_DEPTH), .THRESH(THRESH), .CW(CW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .rd_en_i   (rd_en_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .count_o   (count_o),
  .wr_drop_o (wr_drop_o),
  .rd_drop_o (rd_drop_o),
  .fifo_wr   (fifo_wr),
  .pipe_vld  (pipe_vld)
);

// File: tb/sim_stall_pipe.sv
`timescale 1ns/1ps
module sim_stall_pipe;
  localparam int unsigned W   = 16;
  localparam int unsigned S   = 12;
  localparam int unsigned D   = 32;
  localparam int unsigned T   = 20;
  localparam int unsigned CW  = $clog2(D + 1);
  localparam time         CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ready;
  logic          rd_en = 1'b0;
  logic [W-1:0]  rd_data;
  logic          full, empty, wr_drop, rd_drop;
  logic [CW-1:0] count;

  int total = 0;
  int bad = 0;
  int drop_seen = 0;
  logic [W-1:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_pipe #(.DATA_W(W), .STAGES(S), .FIFO_DEPTH(D), .THRESH(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .rd_en_i(rd_en), .rd_data_o(rd_data), .full_o(full),
    .empty_o(empty), .count_o(count), .wr_drop_o(wr_drop), .rd_drop_o(rd_drop)
  );

  always @(negedge clk) if (rst_n && wr_drop) drop_seen++;

  function automatic logic [W-1:0] xf(input logic [W-1:0] x);
    logic [W-1:0] y = x;
    for (int k = 0; k < S; k++) y = {y[W-2:0], y[W-1]} ^ W'(k);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one negedge step: drive inputs, record acceptance, pop and compare on read
  task automatic step(input bit v, input logic [W-1:0] d, input bit rd, input string tag);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    rd_en    = rd && !empty;
    if (rd_en) begin
      logic [W-1:0] e = expq.pop_front();
      chk(rd_data == e, tag, rd_data, e);
    end
    if (v && in_ready) expq.push_back(xf(d));
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 4 * D + 4 * S && expq.size() != 0; n++) step(1'b0, '0, 1'b1, tag);
    @(negedge clk);
    rd_en = 1'b0;
    chk(expq.size() == 0, {tag, " queue drained"}, expq.size(), 0);
    chk(empty && count == 0, "R9 empty after drain", count, 0);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready, "R1 ready low in reset", in_ready, 0);
      chk(empty && !full && count == 0, "R1 fifo idle in reset", count, 0);
    end
    rst_n = 1'b1;
    #1;
    chk(!in_ready, "R1 ready low before first edge", in_ready, 0);
    @(negedge clk);
    chk(in_ready, "R1 ready after first edge", in_ready, 1);
  endtask

  task automatic t_latency();
    logic [CW-1:0] c0 = count;
    in_valid = 1'b1;
    in_data  = 16'h1234;
    expq.push_back(xf(16'h1234));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (S - 1) @(negedge clk);
    chk(count == c0, "R2 not yet written at S-1", count, c0);
    @(negedge clk);
    chk(count == c0 + 1, "R2 written after S edges", count, c0 + 1);
    chk(rd_data == xf(16'h1234), "R3 transform of 0x1234", rd_data, xf(16'h1234));
    drain("R7 single read");
  endtask

  task automatic t_empty_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_drop, "R8 flag after empty read", rd_drop, 1);
    chk(count == 0 && empty, "R8 count untouched", count, 0);
    @(negedge clk);
    chk(!rd_drop, "R8 flag lasts one cycle", rd_drop, 0);
  endtask

  task automatic t_bubbles();
    int sent = 0;
    for (int i = 0; i < 15; i++) begin
      bit v = (i % 3) != 0;
      step(v, W'(16'hA5C3 + i * 16'h0137), 1'b0, "R4");
      if (v) sent++;
    end
    step(1'b0, '0, 1'b0, "R4");
    repeat (S + 2) @(negedge clk);
    chk(count == CW'(sent), "R4 only valid words stored", count, sent);
    drain("R4/R3 bubble order");
  endtask

  task automatic t_fill();
    for (int i = 0; i < T + S + 8; i++) begin
      step(1'b1, W'(16'h8001 ^ (i * 16'h0F0F)), 1'b0, "R6");
      chk(in_ready == (count < CW'(T)), "R5 ready vs watermark", in_ready, count < CW'(T));
    end
    step(1'b0, '0, 1'b0, "R6");
    repeat (S + 2) @(negedge clk);
    chk(count == CW'(T + S), "R9 settles at THRESH+STAGES", count, T + S);
    chk(full, "R9 full at depth", full, 1);
    chk(!in_ready, "R5 ready low when full", in_ready, 0);
    chk(expq.size() == T + S, "R6 every accepted word landed", expq.size(), T + S);
    chk(drop_seen == 0, "R6 no write on full", drop_seen, 0);
    drain("R6 fill order");
  endtask

  task automatic t_concurrent();
    for (int i = 0; i < 80; i++)
      step(1'b1, W'(i * 16'h2F1D + 7), 1'b1, "R7 concurrent read");
    step(1'b0, '0, 1'b1, "R7 concurrent read");
    chk(drop_seen == 0, "R6 no drops while streaming", drop_seen, 0);
    drain("R7 concurrent drain");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_empty_read();
    t_bubbles();
    t_fill();
    t_concurrent();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
  end
endmodule